// File: doc/BRIEF.md
# Cascaded Two-Stage Interval Timer with LCD Frame Clock

This block is a pair of chained 8-bit counters that provide a periodic interrupt and a frame clock for a display driver. The first counter always runs from a slow auxiliary clock enable. The second counter runs from one of three sources: the auxiliary enable, a fast main clock enable, or the carry out of the first counter, which divides the auxiliary clock by 256. Both clock enables are single-cycle strobes in the block's clock domain.

An 8-bit control register picks the source of the second counter, a hold, the interrupt interval and the display clock divider. The interrupt interval is a bit of the second counter, chosen by the control register. Each time that bit falls from 1 to 0, a sticky flag is set. Software clears the flag with a clear strobe. The display clock is a bit of the first counter, so it gives the auxiliary clock divided by 32, 64, 128 or 256. Both counts can be read at any time.

Top module: `btimer_cascade`

## Requirements
- R1: After synchronous reset, the control register reads 0, both counts read 0, and irq_flag and lcd_clk are 0.
- R2: When ctl_we is high at a clock edge, ctl_q holds ctl_wdata after that edge. Otherwise ctl_q keeps its value.
- R3: With control bit 6 (hold) clear, cnt1_q advances by one, modulo 256, on each edge where aux_en is high. It does not change on any other edge.
- R4: The second counter advances by one, modulo 256, on each advance of its source. With bits 5 and 7 both clear, the source is aux_en. With bit 7 set and bit 5 clear, the source is main_en. With bit 5 set, the source is the edge where cnt1_q advances from 255 to 0, whatever the value of bit 7.
- R5: With bit 6 set and bit 5 clear, cnt1_q is frozen and the second counter keeps counting from its source. With bits 6 and 5 both set, both counts are frozen.
- R6: Let k be control bits 2:0. irq_flag becomes 1 on the edge after which cnt2_q bit k has gone from 1 to 0 because the counter advanced. This gives an interrupt period of the second-stage clock divided by 2^(k+1), that is 2 up to 256.
- R7: irq_flag stays set until an edge with irq_clr high, which clears it. If a new set event falls on the same edge as irq_clr, the flag stays set.
- R8: lcd_clk equals cnt1_q bit (4 + m), where m is control bits 4:3. This divides the auxiliary clock by 32, 64, 128 or 256 for m = 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_en | input | 1 | Slow auxiliary clock enable strobe |
| main_en | input | 1 | Fast main clock enable strobe |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| ctl_q | output | 8 | Control register contents |
| cnt1_q | output | 8 | First-stage count |
| cnt2_q | output | 8 | Second-stage count |
| irq_flag | output | 1 | Sticky interval interrupt flag |
| lcd_clk | output | 1 | Divided display frame clock |

## Verification
A wrong first-stage count shows on cnt1_q and lcd_clk on the same edge. In chained mode, it also delays the next advance of the second counter by up to 256 auxiliary strobes. A wrong source selection or a wrong hold shows on cnt2_q at the first strobe that is taken or missed. A wrong tap or a wrong flag update shows on irq_flag no later than the next set event, which is at most 256 second-stage advances away. Because the model is compared on every clock, each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int CNT_W    = 8;
    localparam int SEL_W    = $clog2(CNT_W);
    localparam int LCD_BASE = 4;

    // Field order follows bit positions 7..0 of the control byte
    typedef struct packed {
        logic       main_src;  // bit 7: fast clock feeds stage two
        logic       hold;      // bit 6: freeze
        logic       chain;     // bit 5: stage two driven by stage-one carry
        logic [1:0] lcd_sel;   // bits 4:3
        logic [2:0] irq_sel;   // bits 2:0
    } bt_ctl_t;

    typedef enum logic [1:0] {
        SRC_AUX   = 2'd0,
        SRC_MAIN  = 2'd1,
        SRC_CHAIN = 2'd2
    } bt_src_e;

    // Chaining overrides the fast-clock selection
    function automatic bt_src_e src_of(input bt_ctl_t c);
        if (c.chain)         return SRC_CHAIN;
        else if (c.main_src) return SRC_MAIN;
        else                 return SRC_AUX;
    endfunction

    function automatic logic [SEL_W-1:0] lcd_tap(input logic [1:0] sel);
        return SEL_W'(LCD_BASE) + SEL_W'(sel);
    endfunction

endpackage

// File: rtl/bt_ctl_reg.sv
module bt_ctl_reg
    import bt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  logic [7:0] wdata,
    output bt_ctl_t   ctl
);

    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (we)
            ctl <= bt_ctl_t'(wdata);
    end

    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (ctl == bt_ctl_t'($past(wdata))));

    // R2
    ctl_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(ctl));

endmodule

// File: rtl/bt_prescale.sv
module bt_prescale
    import bt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         aux_en,
    input  logic         hold,
    input  logic [1:0]   lcd_sel,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         lcd_clk
);

    logic advance;

    assign advance = aux_en && !hold;
    assign wrap    = advance && (&cnt);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (advance)
            cnt <= cnt + 1'b1;
    end

    assign lcd_clk = cnt[lcd_tap(lcd_sel)];

    // R3
    cnt1_step_chk: assert property (@(posedge clk) disable iff (rst)
        (aux_en && !hold) |=> (cnt == $past(cnt) + 1'b1));

    // R5
    cnt1_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!aux_en || hold) |=> $stable(cnt));

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));

endmodule

// File: rtl/bt_stage2.sv
module bt_stage2
    import bt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  bt_src_e          src,
    input  logic             frozen,
    input  logic             aux_en,
    input  logic             main_en,
    input  logic             carry,
    input  logic [SEL_W-1:0] irq_sel,
    input  logic             irq_clr,
    output logic [W-1:0]     cnt,
    output logic             irq_flag
);

    logic         tick;
    logic         step;
    logic         fall;
    logic [W-1:0] ones;

    always_comb begin
        unique case (src)
            SRC_MAIN:  tick = main_en;
            SRC_CHAIN: tick = carry;
            default:   tick = aux_en;
        endcase
    end

    assign step = tick && !frozen;

    // Tap g falls on an advance when bits g..0 are all ones
    for (genvar g = 0; g < W; g++) begin : g_tap
        assign ones[g] = &cnt[g:0];
    end

    assign fall = step && ones[irq_sel];

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_flag <= 1'b0;
        else if (fall)
            irq_flag <= 1'b1;
        else if (irq_clr)
            irq_flag <= 1'b0;
    end

    // R4
    aux_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_AUX && !aux_en) |=> $stable(cnt));

    // R4
    main_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_MAIN && !main_en) |=> $stable(cnt));

    // R4
    chain_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_CHAIN && !carry) |=> $stable(cnt));

    // R5
    both_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        frozen |=> $stable(cnt));

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        fall |=> irq_flag);

    // R6
    flag_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_flag && !fall) |=> !irq_flag);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !fall) |=> !irq_flag);

endmodule

// File: rtl/btimer_cascade.sv
module btimer_cascade
    import bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       aux_en,
    input  logic       main_en,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    input  logic       irq_clr,
    output logic [7:0] ctl_q,
    output logic [7:0] cnt1_q,
    output logic [7:0] cnt2_q,
    output logic       irq_flag,
    output logic       lcd_clk
);

    bt_ctl_t ctl;
    logic    carry;
    bt_src_e src;
    logic    frz2;

    bt_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    bt_prescale #(.W(CNT_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .aux_en  (aux_en),
        .hold    (ctl.hold),
        .lcd_sel (ctl.lcd_sel),
        .cnt     (cnt1_q),
        .wrap    (carry),
        .lcd_clk (lcd_clk)
    );

    assign src  = src_of(ctl);
    assign frz2 = ctl.hold && ctl.chain;

    bt_stage2 #(.W(CNT_W)) u_st2 (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .frozen   (frz2),
        .aux_en   (aux_en),
        .main_en  (main_en),
        .carry    (carry),
        .irq_sel  (ctl.irq_sel),
        .irq_clr  (irq_clr),
        .cnt      (cnt2_q),
        .irq_flag (irq_flag)
    );

    assign ctl_q = 8'(ctl);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ctl_q == 8'h00 && cnt1_q == 8'h00 && cnt2_q == 8'h00 && !irq_flag));

endmodule

// File: tb/sim_btimer_cascade.sv
module sim_btimer_cascade;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       aux_en = 1'b0;
    logic       main_en = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       irq_clr = 1'b0;
    logic [7:0] ctl_q, cnt1_q, cnt2_q;
    logic       irq_flag, lcd_clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural reference state
    int m_ctl = 0, m_c1 = 0, m_c2 = 0, m_flag = 0;

    always #5 clk = ~clk;

    btimer_cascade u0 (
        .clk(clk), .rst(rst), .aux_en(aux_en), .main_en(main_en),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .irq_clr(irq_clr),
        .ctl_q(ctl_q), .cnt1_q(cnt1_q), .cnt2_q(cnt2_q),
        .irq_flag(irq_flag), .lcd_clk(lcd_clk)
    );

    always @(posedge clk) begin
        int hold, chn, fast, code, c2_tick, old_bit, new_bit, nc2;
        if (rst) begin
            m_ctl = 0; m_c1 = 0; m_c2 = 0; m_flag = 0;
        end else begin
            hold = (m_ctl >> 6) & 1;
            chn  = (m_ctl >> 5) & 1;
            fast = (m_ctl >> 7) & 1;
            code = m_ctl & 7;
            if (chn != 0)
                c2_tick = (aux_en && hold == 0 && m_c1 == 255) ? 1 : 0;
            else if (fast != 0)
                c2_tick = main_en ? 1 : 0;
            else
                c2_tick = aux_en ? 1 : 0;
            if (aux_en && hold == 0)
                m_c1 = (m_c1 + 1) % 256;
            if (c2_tick != 0) begin
                nc2     = (m_c2 + 1) % 256;
                old_bit = (m_c2 >> code) & 1;
                new_bit = (nc2 >> code) & 1;
                m_c2    = nc2;
                if (old_bit == 1 && new_bit == 0)
                    m_flag = 1;
                else if (irq_clr)
                    m_flag = 0;
            end else if (irq_clr) begin
                m_flag = 0;
            end
            if (ctl_we)
                m_ctl = int'(ctl_wdata);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 ctl_q", int'(ctl_q), m_ctl);
        chk("R3 cnt1_q", int'(cnt1_q), m_c1);
        chk("R4 cnt2_q", int'(cnt2_q), m_c2);
        chk("R6 irq_flag", int'(irq_flag), m_flag);
        chk("R8 lcd_clk", int'(lcd_clk), (m_c1 >> (4 + ((m_ctl >> 3) & 3))) & 1);
    endtask

    task automatic cyc(input bit a, input bit m, input bit c);
        @(negedge clk);
        compare_all();
        aux_en = a; main_en = m; irq_clr = c; ctl_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        compare_all();
        aux_en = 1'b0; main_en = 1'b0; irq_clr = 1'b0;
        ctl_we = 1'b1; ctl_wdata = v;
    endtask

    task automatic run_rand(input int n, input int aux_mask, input int main_mask, input int clr_mask);
        for (int i = 0; i < n; i++)
            cyc(($urandom & aux_mask) == 0, ($urandom & main_mask) == 0,
                ($urandom & clr_mask) == 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int s1, s2;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk("R1 ctl_q", int'(ctl_q), 0);
        chk("R1 cnt1_q", int'(cnt1_q), 0);
        chk("R1 cnt2_q", int'(cnt2_q), 0);
        chk("R1 irq_flag", int'(irq_flag), 0);
        chk("R1 lcd_clk", int'(lcd_clk), 0);
        rst = 1'b0;

        // R3 R6: default tap, auxiliary source
        run_rand(800, 1, 0, 7);
        // R8 R6: lcd divide 256, tap 3
        wr(8'h1B);
        run_rand(800, 1, 1, 15);
        // R4: fast clock source, tap 5
        wr(8'h85);
        run_rand(1500, 0, 1, 31);
        // R4 R6: chained source, tap 0, lcd divide 64
        wr(8'h28);
        run_rand(1600, 0, 1, 63);
        // R4: chaining takes precedence over the fast clock
        wr(8'hA0);
        run_rand(800, 0, 0, 63);
        // R8: lcd divide 128
        wr(8'h12);
        run_rand(600, 0, 1, 7);

        // R5: hold without chaining freezes only the first stage
        wr(8'h40);
        cyc(0, 0, 0);
        s1 = int'(cnt1_q); s2 = int'(cnt2_q);
        repeat (30) cyc(1, 0, 0);
        cyc(0, 0, 0);
        chk("R5 cnt1 frozen", int'(cnt1_q), s1);
        chk("R5 cnt2 runs", int'(cnt2_q), (s2 + 30) % 256);

        // R5: hold with chaining freezes both
        wr(8'h60);
        cyc(0, 0, 0);
        s1 = int'(cnt1_q); s2 = int'(cnt2_q);
        repeat (300) cyc(1, 1, 0);
        cyc(0, 0, 0);
        chk("R5 cnt1 frozen chained", int'(cnt1_q), s1);
        chk("R5 cnt2 frozen chained", int'(cnt2_q), s2);

        // R7: flag sticky until cleared
        wr(8'h00);
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        repeat (20) cyc(0, 0, 0);
        chk("R7 flag held", int'(irq_flag), 1);
        cyc(0, 0, 1);
        cyc(0, 0, 0);
        chk("R7 flag cleared", int'(irq_flag), 0);

        // R7: set and clear on the same edge, set wins
        run_rand(400, 0, 0, 0);
        run_rand(200, 1, 1, 1);
        cyc(0, 0, 0);

        finish_run();
    end

endmodule